// File: doc/BRIEF.md
# Mux-Scan Chain Test Sequencer

This controller drives an external chain of mux-D scan flip-flops that stands in front of a combinational core. Each flip-flop in the chain has a clock enable and a scan-select. The controller raises scan-select to shift. It drops scan-select and pulses the clock enable once to capture the core's response. Before any pattern is applied, it proves the chain with a built-in integrity test, which is either a repeating two-zeros/two-ones stream or a clear-then-single-one flush. Each test run then loads a fixed number of patterns. Each captured response is unloaded while the next pattern is loaded. A final unload shifts zeros in.

Patterns arrive as a serial stream with valid/ready, and responses leave as a serial stream with valid/ready. The two streams move in lock-step during a load: a chain shift happens only when a pattern bit is offered and, if a response is pending, the response sink accepts. `rsp_valid` therefore depends on `pat_valid`, and `pat_ready` depends on `rsp_ready`, but neither valid depends on its own ready. Back-pressure on either side stalls the chain with its clock enable low.

While scan-select is high, the controller also forces the functional clear and preset inputs of the chain inactive. It blocks RAM writes and turns off bidirectional pad drivers. A one-hot decoder on the internal bus driver selects guarantees a single active driver at most.

Top module: `scan_seq_top`

## Requirements
- R1: After reset, `chain_se`, `chain_en`, `pat_ready`, `rsp_valid`, `done` and `fail` are all 0.
- R2: A shift step is a cycle with `chain_se`=1 and `chain_en`=1. During a load, every accepted pattern bit is presented on `chain_si` in a shift step. The first bit of a pattern ends in the cell farthest from the chain input.
- R3: After the last shift of a pattern, `chain_se` and `chain_en` are both low for exactly SETTLE_CYC cycles before the capture.
- R4: Capture is a single cycle with `chain_en`=1 and `chain_se`=0.
- R5: A response is unloaded on `chain_so`/`rsp_bit` in the same shift steps that load the next pattern, last chain cell first. After the final pattern, CHAIN_LEN more shifts unload the last response. No response is emitted before the first capture.
- R6: In a load, `pat_ready` = 1 when no response is pending or `rsp_ready` = 1. A shift happens exactly when `pat_valid` and `pat_ready` are both 1. In the final unload, a shift happens exactly when `rsp_ready` = 1.
- R7: With `flush_mode`=0 at start, the integrity test drives 0,0,1,1 repeating on `chain_si` for 2*CHAIN_LEN+4 shifts. Every bit seen on `chain_so` must equal the bit sent CHAIN_LEN shifts earlier.
- R8: With `flush_mode`=1, the test sends CHAIN_LEN zeros, then a single 1, then zeros. `chain_so` must be 1 exactly CHAIN_LEN shifts after the 1 is sent and 0 at the other compared shifts.
- R9: `fail` sets on the first integrity mismatch and holds until the next accepted `start`. After a failure, no pattern is requested and no response is emitted.
- R10: `done` is high for exactly one cycle, after the final unload shift or after a failed integrity test.
- R11: While `chain_se`=1, `clr_n_out` and `pre_n_out` are 1, and `ram_we` and `bidir_oe` are 0. Otherwise these outputs follow their requests.
- R12: `drv_en` has bit `drv_sel` set when `drv_req`=1 and is all zero otherwise, so at most one bus driver is on in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run (taken only when idle) |
| flush_mode | input | 1 | Integrity test variant, latched at start: 0 stream, 1 flush |
| pat_valid | input | 1 | Pattern bit offered |
| pat_ready | output | 1 | Pattern bit can be taken |
| pat_bit | input | 1 | Pattern bit |
| rsp_valid | output | 1 | Response bit offered |
| rsp_ready | input | 1 | Response sink accepts |
| rsp_bit | output | 1 | Response bit |
| chain_se | output | 1 | Scan-select for every chain cell |
| chain_en | output | 1 | Clock enable for every chain cell |
| chain_si | output | 1 | Serial input of the chain |
| chain_so | input | 1 | Serial output of the chain |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky integrity failure |
| func_clr_n | input | 1 | Functional async clear request, active low |
| func_pre_n | input | 1 | Functional async preset request, active low |
| ram_we_req | input | 1 | Functional RAM write enable |
| bidir_oe_req | input | 1 | Functional pad output enable |
| drv_req | input | 1 | Some bus driver requested |
| drv_sel | input | $clog2(NUM_DRV) | Index of the requested bus driver |
| clr_n_out | output | 1 | Gated clear to chain cells |
| pre_n_out | output | 1 | Gated preset to chain cells |
| ram_we | output | 1 | Gated RAM write enable |
| bidir_oe | output | 1 | Gated pad output enable |
| drv_en | output | NUM_DRV | One-hot bus driver enables |

## Verification
All controller outputs are decoded combinationally from registered state, so each result is checked in the cycle it is produced, one nanosecond before the edge that acts on it. A pattern bit and the response bit paired with it are compared in the very cycle of their handshake. The integrity-test input bits are compared on the cycle after `start` and on each of the next CHAIN_LEN cycles. The settle gap and capture width are measured as run lengths of `chain_se`/`chain_en` levels. `done` and `fail` are judged a few cycles after the pulse, and `fail` again ten cycles later for stickiness.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEG,
    ST_LOAD,
    ST_SETTLE,
    ST_CAPT,
    ST_UNLOAD,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/scan_integ_chk.sv
// Chain integrity generator and comparator: stream (0011...) or flush (single 1).
module scan_integ_chk #(
  parameter int CHAIN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic flush_mode,
  input  logic active,
  input  logic chain_so,
  output logic test_bit,
  output logic last,
  output logic mismatch,
  output logic fail
);
  localparam int TEST_LEN = 2 * CHAIN_LEN + 4;
  localparam int CW = $clog2(TEST_LEN + 1);
  localparam logic [CW-1:0] LEN_C  = CW'(CHAIN_LEN);
  localparam logic [CW-1:0] LAST_C = CW'(TEST_LEN - 1);

  logic [CW-1:0] cnt;
  logic          mode_q;
  logic          exp_bit;
  logic          compare;

  function automatic logic ref_bit(input logic [CW-1:0] idx, input logic fm);
    return fm ? (idx == LEN_C) : idx[1];
  endfunction

  assign test_bit = ref_bit(cnt, mode_q);
  assign compare  = active && (cnt >= LEN_C);
  assign exp_bit  = ref_bit(cnt - LEN_C, mode_q);
  assign mismatch = compare && (chain_so != exp_bit);
  assign last     = active && (cnt == LAST_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_q <= 1'b0;
      fail   <= 1'b0;
    end else if (clear) begin
      cnt    <= '0;
      mode_q <= flush_mode;
      fail   <= 1'b0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
      if (mismatch) fail <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_safety_gate.sv
// Shift-mode protection of clears, RAM writes, pads and bus drivers.
module scan_safety_gate #(
  parameter int NUM_DRV = 4
) (
  input  logic                       shifting,
  input  logic                       func_clr_n,
  input  logic                       func_pre_n,
  input  logic                       ram_we_req,
  input  logic                       bidir_oe_req,
  input  logic                       drv_req,
  input  logic [$clog2(NUM_DRV)-1:0] drv_sel,
  output logic                       clr_n_out,
  output logic                       pre_n_out,
  output logic                       ram_we,
  output logic                       bidir_oe,
  output logic [NUM_DRV-1:0]         drv_en
);
  localparam int SW = $clog2(NUM_DRV);

  assign clr_n_out = func_clr_n | shifting;
  assign pre_n_out = func_pre_n | shifting;
  assign ram_we    = ram_we_req & ~shifting;
  assign bidir_oe  = bidir_oe_req & ~shifting;

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_dec
    assign drv_en[g] = drv_req && (drv_sel == SW'(g));
  end
endmodule

// File: rtl/scan_seq_ctrl.sv
// Phase sequencer: integrity, load/unload overlap, settle, capture, final unload.
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN  = 8,
  parameter int NUM_PAT    = 4,
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic integ_last,
  input  logic integ_bad,
  input  logic pat_valid,
  input  logic rsp_ready,
  output logic launch,
  output logic integ_active,
  output logic load_phase,
  output logic se,
  output logic en,
  output logic pat_ready,
  output logic rsp_valid,
  output logic done
);
  localparam int MAXC = (CHAIN_LEN > SETTLE_CYC) ? CHAIN_LEN : SETTLE_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam int PW = $clog2(NUM_PAT + 1);
  localparam logic [CW-1:0] SHIFT_LAST  = CW'(CHAIN_LEN - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [PW-1:0] PAT_LAST    = PW'(NUM_PAT - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pidx;
  logic          have_rsp;

  always_comb begin
    launch       = 1'b0;
    integ_active = 1'b0;
    load_phase   = 1'b0;
    se           = 1'b0;
    en           = 1'b0;
    pat_ready    = 1'b0;
    rsp_valid    = 1'b0;
    done         = 1'b0;
    unique case (state)
      ST_IDLE:   launch = start;
      ST_INTEG: begin
        integ_active = 1'b1;
        se           = 1'b1;
        en           = 1'b1;
      end
      ST_LOAD: begin
        load_phase = 1'b1;
        se         = 1'b1;
        pat_ready  = !have_rsp || rsp_ready;
        rsp_valid  = have_rsp && pat_valid;
        en         = pat_valid && pat_ready;
      end
      ST_SETTLE: ;
      ST_CAPT:   en = 1'b1;
      ST_UNLOAD: begin
        se        = 1'b1;
        rsp_valid = 1'b1;
        en        = rsp_ready;
      end
      ST_DONE:   done = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pidx     <= '0;
      have_rsp <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_INTEG;
          cnt      <= '0;
          pidx     <= '0;
          have_rsp <= 1'b0;
        end
        ST_INTEG: if (integ_last) begin
          state <= integ_bad ? ST_DONE : ST_LOAD;
          cnt   <= '0;
        end
        ST_LOAD: if (en) begin
          if (cnt == SHIFT_LAST) begin
            cnt   <= '0;
            state <= ST_SETTLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            cnt   <= '0;
            state <= ST_CAPT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CAPT: begin
          have_rsp <= 1'b1;
          if (pidx == PAT_LAST) begin
            state <= ST_UNLOAD;
          end else begin
            pidx  <= pidx + 1'b1;
            state <= ST_LOAD;
          end
        end
        ST_UNLOAD: if (en) begin
          if (cnt == SHIFT_LAST) begin
            cnt   <= '0;
            state <= ST_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int CHAIN_LEN  = 8,
  parameter int NUM_PAT    = 4,
  parameter int SETTLE_CYC = 2,
  parameter int NUM_DRV    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       flush_mode,
  input  logic                       pat_valid,
  output logic                       pat_ready,
  input  logic                       pat_bit,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       rsp_bit,
  output logic                       chain_se,
  output logic                       chain_en,
  output logic                       chain_si,
  input  logic                       chain_so,
  output logic                       done,
  output logic                       fail,
  input  logic                       func_clr_n,
  input  logic                       func_pre_n,
  input  logic                       ram_we_req,
  input  logic                       bidir_oe_req,
  input  logic                       drv_req,
  input  logic [$clog2(NUM_DRV)-1:0] drv_sel,
  output logic                       clr_n_out,
  output logic                       pre_n_out,
  output logic                       ram_we,
  output logic                       bidir_oe,
  output logic [NUM_DRV-1:0]         drv_en
);
  logic launch, integ_active, load_phase;
  logic integ_bit, integ_last, integ_mis;

  scan_seq_ctrl #(
    .CHAIN_LEN (CHAIN_LEN),
    .NUM_PAT   (NUM_PAT),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .integ_last  (integ_last),
    .integ_bad   (fail | integ_mis),
    .pat_valid   (pat_valid),
    .rsp_ready   (rsp_ready),
    .launch      (launch),
    .integ_active(integ_active),
    .load_phase  (load_phase),
    .se          (chain_se),
    .en          (chain_en),
    .pat_ready   (pat_ready),
    .rsp_valid   (rsp_valid),
    .done        (done)
  );

  scan_integ_chk #(.CHAIN_LEN(CHAIN_LEN)) u_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .flush_mode(flush_mode),
    .active    (integ_active),
    .chain_so  (chain_so),
    .test_bit  (integ_bit),
    .last      (integ_last),
    .mismatch  (integ_mis),
    .fail      (fail)
  );

  scan_safety_gate #(.NUM_DRV(NUM_DRV)) u_gate (
    .shifting    (chain_se),
    .func_clr_n  (func_clr_n),
    .func_pre_n  (func_pre_n),
    .ram_we_req  (ram_we_req),
    .bidir_oe_req(bidir_oe_req),
    .drv_req     (drv_req),
    .drv_sel     (drv_sel),
    .clr_n_out   (clr_n_out),
    .pre_n_out   (pre_n_out),
    .ram_we      (ram_we),
    .bidir_oe    (bidir_oe),
    .drv_en      (drv_en)
  );

  assign chain_si = integ_active ? integ_bit : (load_phase & pat_bit);
  assign rsp_bit  = chain_so;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int NUM_DRV = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               chain_se,
  input logic               chain_en,
  input logic               pat_ready,
  input logic               done,
  input logic               fail,
  input logic               clr_n_out,
  input logic               pre_n_out,
  input logic               ram_we,
  input logic               bidir_oe,
  input logic [NUM_DRV-1:0] drv_en
);
  a_r4_capture_single: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && !chain_se) |=> !(chain_en && !chain_se));

  a_r3_settle_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chain_se) |-> !chain_en);

  a_r11_shift_safe: assert property (@(posedge clk) disable iff (!rst_n)
    chain_se |-> (clr_n_out && pre_n_out && !ram_we && !bidir_oe));

  a_r12_bus_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_en));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  a_r6_ready_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    pat_ready |-> chain_se);
endmodule

bind scan_seq_top scan_seq_chk #(.NUM_DRV(NUM_DRV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .chain_se (chain_se),
  .chain_en (chain_en),
  .pat_ready(pat_ready),
  .done     (done),
  .fail     (fail),
  .clr_n_out(clr_n_out),
  .pre_n_out(pre_n_out),
  .ram_we   (ram_we),
  .bidir_oe (bidir_oe),
  .drv_en   (drv_en)
);

// File: tb/scan_seq_top_test.sv
module scan_seq_top_test;
  localparam int N  = 8;
  localparam int NP = 4;
  localparam int ST = 2;
  localparam int ND = 4;
  localparam logic [N-1:0] XMASK = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, flush_mode = 1'b0;
  logic pat_valid = 1'b0, pat_bit = 1'b0, rsp_ready = 1'b0;
  logic pat_ready, rsp_valid, rsp_bit;
  logic chain_se, chain_en, chain_si, chain_so;
  logic done, fail;
  logic func_clr_n = 1'b0, func_pre_n = 1'b0, ram_we_req = 1'b1, bidir_oe_req = 1'b1;
  logic drv_req = 1'b0;
  logic [$clog2(ND)-1:0] drv_sel = '0;
  logic clr_n_out, pre_n_out, ram_we, bidir_oe;
  logic [ND-1:0] drv_en;

  int checks = 0, errors = 0;
  int pat_seen = 0, rsp_seen = 0, done_cnt = 0;
  int cap_run = 0, idle_run = 0;
  bit stall = 1'b0, stuck = 1'b0, extra = 1'b0;
  bit pq[$];
  bit eq[$];

  always #4 clk = ~clk;

  scan_seq_top #(.CHAIN_LEN(N), .NUM_PAT(NP), .SETTLE_CYC(ST), .NUM_DRV(ND)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .flush_mode(flush_mode),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_bit(pat_bit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bit(rsp_bit),
    .chain_se(chain_se), .chain_en(chain_en), .chain_si(chain_si), .chain_so(chain_so),
    .done(done), .fail(fail),
    .func_clr_n(func_clr_n), .func_pre_n(func_pre_n), .ram_we_req(ram_we_req),
    .bidir_oe_req(bidir_oe_req), .drv_req(drv_req), .drv_sel(drv_sel),
    .clr_n_out(clr_n_out), .pre_n_out(pre_n_out), .ram_we(ram_we),
    .bidir_oe(bidir_oe), .drv_en(drv_en)
  );

  // Behavioural scan chain with core and fault injection
  logic [N-1:0] q = '0;
  logic xq = 1'b0;
  function automatic logic [N-1:0] core_f(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]} ^ XMASK;
  endfunction
  always @(posedge clk) begin
    if (chain_en) begin
      if (chain_se) begin
        q  <= {q[N-2:0], chain_si};
        xq <= q[N-1];
      end else begin
        q <= core_f(q);
      end
    end
  end
  assign chain_so = stuck ? 1'b1 : (extra ? xq : q[N-1]);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Stream driver and monitor: drive at negedge, judge 1 ns before posedge
  initial forever begin
    @(negedge clk);
    pat_valid = (pq.size() > 0) && (!stall || $urandom_range(0, 2) != 0);
    pat_bit   = (pq.size() > 0) ? pq[0] : 1'b0;
    rsp_ready = !stall || ($urandom_range(0, 1) == 1);
    #3;
    if (pat_valid && pat_ready) begin
      chk(chain_si == pat_bit && chain_se && chain_en, "R2 pattern shift", {chain_si, chain_se, chain_en}, {pat_bit, 2'b11});
      void'(pq.pop_front());
      pat_seen++;
    end
    if (rsp_valid && rsp_ready) begin
      if (eq.size() == 0) chk(1'b0, "R5 unexpected response", 1, 0);
      else begin
        bit e;
        e = eq.pop_front();
        chk(rsp_bit == e, "R5 response bit", rsp_bit, e);
      end
      rsp_seen++;
    end
    if (pat_ready) chk(chain_en == pat_valid, "R6 shift on handshake", chain_en, pat_valid);
    if (chain_se && rsp_valid && !rsp_ready) chk(!chain_en, "R6 stall on sink", chain_en, 0);
    // R4 capture width, R3 settle gap
    if (!chain_se && chain_en) cap_run++;
    else begin
      if (cap_run > 0) chk(cap_run == 1, "R4 capture width", cap_run, 1);
      cap_run = 0;
    end
    if (chain_se) idle_run = 0;
    else if (!chain_en) idle_run++;
    else chk(idle_run == ST, "R3 settle gap", idle_run, ST);
    // R11 gating
    if (chain_se)
      chk(clr_n_out && pre_n_out && !ram_we && !bidir_oe, "R11 shift gating",
          {clr_n_out, pre_n_out, ram_we, bidir_oe}, 4'b1100);
    else
      chk(clr_n_out == func_clr_n && pre_n_out == func_pre_n && ram_we == ram_we_req && bidir_oe == bidir_oe_req,
          "R11 pass-through", {clr_n_out, pre_n_out, ram_we, bidir_oe}, {func_clr_n, func_pre_n, ram_we_req, bidir_oe_req});
    if (done) begin
      done_cnt++;
      chk(eq.size() == 0, "R10 done after unload", eq.size(), 0);
    end
  end

  // Driver task: queues patterns and expected responses, runs one test
  task automatic run(input bit fm, input bit exp_fail, input bit stall_i);
    int p0, r0, d0, w;
    stall = stall_i;
    flush_mode = fm;
    if (!exp_fail) begin
      for (int k = 0; k < NP; k++) begin
        logic [N-1:0] v, r;
        v = N'($urandom);
        r = core_f(v);
        for (int b = N - 1; b >= 0; b--) begin
          pq.push_back(v[b]);
          eq.push_back(r[b]);
        end
      end
    end
    p0 = pat_seen; r0 = rsp_seen; d0 = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i <= N; i++) begin
      #1;
      if (i == 0) chk(fail == 1'b0, "R9 clear on start", fail, 0);
      if (fm) chk(chain_si == (i == N), "R8 flush input", chain_si, (i == N));
      else    chk(chain_si == i[1], "R7 stream input", chain_si, i[1]);
      @(negedge clk);
    end
    w = 0;
    while (done_cnt == d0 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt - d0 == 1, "R10 done one cycle", done_cnt - d0, 1);
    chk(fail == exp_fail, fm ? "R8 flush verdict" : "R7 stream verdict", fail, exp_fail);
    if (exp_fail)
      chk(pat_seen == p0 && rsp_seen == r0, "R9 patterns skipped", pat_seen - p0 + rsp_seen - r0, 0);
    else
      chk(pq.size() == 0 && eq.size() == 0 && rsp_seen - r0 == NP * N, "R5 all responses",
          rsp_seen - r0, NP * N);
    repeat (10) @(negedge clk);
    chk(fail == exp_fail, "R9 fail sticky", fail, exp_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({chain_se, chain_en, pat_ready, rsp_valid, done, fail} == 6'b0, "R1 reset state",
        {chain_se, chain_en, pat_ready, rsp_valid, done, fail}, 0);
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < ND; s++) begin
        drv_req = r[0];
        drv_sel = s[$clog2(ND)-1:0];
        #1;
        chk(drv_en == (r[0] ? ND'(1) << s : ND'(0)), "R12 driver decode", drv_en, r[0] ? (1 << s) : 0);
        @(negedge clk);
      end
    end
    drv_req = 1'b1;
    run(1'b0, 1'b0, 1'b0);
    run(1'b1, 1'b0, 1'b1);
    extra = 1'b1;
    run(1'b0, 1'b1, 1'b0);
    run(1'b1, 1'b1, 1'b0);
    extra = 1'b0;
    stuck = 1'b1;
    run(1'b1, 1'b1, 1'b1);
    stuck = 1'b0;
    run(1'b0, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule